// File: doc/BRIEF.md
# Prefixed Add-Immediate Decode and Execute Unit

This unit accepts one 32-bit instruction word per accepted handshake, along with the address of that word. It executes the add-immediate operation in two encodings. The short encoding is a single D-form word with a 16-bit signed immediate. The long encoding is a prefix word followed by a D-form suffix; the two words together carry a 34-bit signed immediate.

The unit reads the base register through a combinational read port. The read index is driven from the base-register field of the word currently presented. A zero base field selects a literal zero instead of register 0. In the long encoding, a relative flag in the prefix selects the prefix word's own address as the base.

The unit writes only the destination register, reported as an index and a 64-bit value with a single-cycle valid pulse. Vector-extension prefixes and any other opcode are reported as unsupported and are not executed. Malformed prefixes and bad suffixes are reported as illegal.

Bit numbering in the requirements is big-endian: bit 0 is the MSB of the word, which is `in_word[31]`.

Top module: `addimm_exec`

## Requirements
- R1: A word with primary opcode 14 (bits 0-5) accepted while no prefix is held produces, one cycle after the accepting edge, `out_valid`=1 with `out_rt` = bits 6-10 and `out_result` = base + sign-extension of bits 16-31 to 64 bits. The base is the register named by bits 11-15, read on `rd_idx`/`rd_data`.
- R2: When the base field (bits 11-15) is 0 and no relative prefix is held, the base is the literal value 0, whatever `rd_data` carries.
- R3: A prefix word has bits 0-5 = 1, bits 6-7 = 2, bit 8 = 0, bits 9-10 = 0 and bits 12-13 = 0. It produces no output. The next accepted word, if it has opcode 14, yields `out_rt` = its bits 6-10 and `out_result` = (RA|0) + sign-extension to 64 bits of the 34-bit value {prefix bits 14-31, suffix bits 16-31}. This is the case when prefix bit 11 (relative flag) is 0.
- R4: When prefix bit 11 is 1, the base is the address presented with the prefix word. The suffix's base field, `rd_data` and the address presented with the suffix have no effect.
- R5: A word with opcode 9 accepted while no prefix is held gives `out_unsup`=1 one cycle later and no write. The next accepted word is discarded with no output of any kind.
- R6: With no prefix held, any opcode other than 14, 1 and 9, and opcode 1 with bits 6-7 not equal to 2, gives `out_unsup`=1 one cycle later and no write.
- R7: When a prefix is held and the next accepted word's opcode is not 14, the unit gives `out_illegal`=1 one cycle later and no write. The following word is decoded as a fresh instruction.
- R8: A word with opcode 1 and bits 6-7 = 2 but with bit 8, bits 9-10 or bits 12-13 non-zero gives `out_illegal`=1 one cycle later and no write. No prefix is held afterwards.
- R9: While reset is asserted and just after it is released, `out_valid`, `out_illegal` and `out_unsup` are 0.
- R10: At most one of `out_valid`, `out_illegal`, `out_unsup` is 1 in any cycle. All three are 0 in the cycle after an edge at which `in_valid` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word and address are presented this cycle |
| in_word | input | 32 | Instruction word (`in_word[31]` is bit 0) |
| in_addr | input | 64 | Address of the presented word |
| rd_idx | output | 5 | Register read index (base field of `in_word`) |
| rd_data | input | 64 | Register contents for `rd_idx`, same cycle |
| out_valid | output | 1 | Destination write pulse |
| out_rt | output | 5 | Destination register index |
| out_result | output | 64 | Value written to the destination |
| out_illegal | output | 1 | Malformed prefix or bad suffix pulse |
| out_unsup | output | 1 | Unsupported opcode pulse |

## Verification
Every result, illegal and unsupported pulse is due exactly one cycle after the rising edge that accepts its word. For the long encoding, that word is the suffix; the prefix itself must leave all three flags low one cycle after its own edge. The bench presents each word at a falling edge and lets one rising edge take it. At the next falling edge, it compares all flags, the index and the value against a bench-computed model, and then drops `in_valid`. This keeps each check on the cycle the registered outputs change. Discarded suffixes after a vector prefix, and idle cycles, are checked the same way for silence.

// File: rtl/addimm_pkg.sv
package addimm_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned OPC_W    = 6;
   localparam int unsigned REG_W    = 5;
   localparam int unsigned IMM_LO_W = 16;
   localparam int unsigned IMM_HI_W = 18;
   localparam int unsigned IMM_W    = IMM_LO_W + IMM_HI_W;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HELD = 2'd1,
      ST_SKIP = 2'd2
   } seq_state_e;

   // Word fields, LSB-numbered slices of a big-endian word
   typedef struct packed {
      logic [OPC_W-1:0]    opcode;   // bits 0-5
      logic [REG_W-1:0]    rt;       // bits 6-10
      logic [REG_W-1:0]    ra;       // bits 11-15
      logic [IMM_LO_W-1:0] imm_lo;   // bits 16-31
      logic [1:0]          pfx_kind; // bits 6-7
      logic                pfx_b8;   // bit 8
      logic [1:0]          pfx_rsv_a;// bits 9-10
      logic                pfx_rel;  // bit 11
      logic [1:0]          pfx_rsv_b;// bits 12-13
      logic [IMM_HI_W-1:0] imm_hi;   // bits 14-31
   } word_fields_t;

endpackage

// File: rtl/addimm_field_split.sv
module addimm_field_split
   import addimm_pkg::*;
#(
   parameter int unsigned ADD_OPC  = 14,
   parameter int unsigned PFX_OPC  = 1,
   parameter int unsigned VEC_OPC  = 9,
   parameter int unsigned PFX_KIND = 2
) (
   input  logic [WORD_W-1:0] word,
   output word_fields_t      f,
   output logic              is_add,
   output logic              is_pfx,
   output logic              pfx_clean,
   output logic              is_vec
);

   generate
      if (ADD_OPC >= (1 << OPC_W) || PFX_OPC >= (1 << OPC_W) || VEC_OPC >= (1 << OPC_W))
         $error("opcode parameter does not fit the opcode field");
      if (PFX_KIND > 3)
         $error("prefix kind does not fit its two-bit field");
      if (ADD_OPC == PFX_OPC || ADD_OPC == VEC_OPC || PFX_OPC == VEC_OPC)
         $error("opcode parameters must differ");
   endgenerate

   always_comb begin
      f.opcode    = word[31:26];
      f.rt        = word[25:21];
      f.ra        = word[20:16];
      f.imm_lo    = word[15:0];
      f.pfx_kind  = word[25:24];
      f.pfx_b8    = word[23];
      f.pfx_rsv_a = word[22:21];
      f.pfx_rel   = word[20];
      f.pfx_rsv_b = word[19:18];
      f.imm_hi    = word[17:0];
   end

   assign is_add    = (f.opcode == OPC_W'(ADD_OPC));
   assign is_pfx    = (f.opcode == OPC_W'(PFX_OPC)) && (f.pfx_kind == 2'(PFX_KIND));
   assign pfx_clean = !f.pfx_b8 && (f.pfx_rsv_a == 2'b00) && (f.pfx_rsv_b == 2'b00);
   assign is_vec    = (f.opcode == OPC_W'(VEC_OPC));

endmodule

// File: rtl/addimm_seq.sv
module addimm_seq
   import addimm_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                i_valid,
   input  logic [XLEN-1:0]     i_addr,
   input  word_fields_t        f,
   input  logic                is_add,
   input  logic                is_pfx,
   input  logic                pfx_clean,
   input  logic                is_vec,
   output seq_state_e          state,
   output logic                load,
   output logic [IMM_HI_W-1:0] hold_hi,
   output logic                hold_rel,
   output logic [XLEN-1:0]     hold_addr,
   output logic                o_valid,
   output logic                o_illegal,
   output logic                o_unsup
);

   seq_state_e state_nx;
   logic       cap;
   logic       ill_nx;
   logic       uns_nx;

   always_comb begin
      state_nx = state;
      load     = 1'b0;
      cap      = 1'b0;
      ill_nx   = 1'b0;
      uns_nx   = 1'b0;
      if (i_valid) begin
         unique case (state)
            ST_IDLE: begin
               if (is_add) begin
                  load = 1'b1;
               end else if (is_pfx && pfx_clean) begin
                  cap      = 1'b1;
                  state_nx = ST_HELD;
               end else if (is_pfx) begin
                  ill_nx = 1'b1;
               end else if (is_vec) begin
                  uns_nx   = 1'b1;
                  state_nx = ST_SKIP;
               end else begin
                  uns_nx = 1'b1;
               end
            end
            ST_HELD: begin
               state_nx = ST_IDLE;
               if (is_add) load   = 1'b1;
               else        ill_nx = 1'b1;
            end
            ST_SKIP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         o_valid   <= 1'b0;
         o_illegal <= 1'b0;
         o_unsup   <= 1'b0;
         hold_hi   <= '0;
         hold_rel  <= 1'b0;
         hold_addr <= '0;
      end else begin
         state     <= state_nx;
         o_valid   <= load;
         o_illegal <= ill_nx;
         o_unsup   <= uns_nx;
         if (cap) begin
            hold_hi   <= f.imm_hi;
            hold_rel  <= f.pfx_rel;
            hold_addr <= i_addr;
         end
      end
   end

   // R10: flags are mutually exclusive
   a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({o_valid, o_illegal, o_unsup}));

   // R10: no accepted word, no flag next cycle
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !i_valid |=> !(o_valid || o_illegal || o_unsup));

   // R3: a well-formed prefix is held silently
   a_r3_prefix_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && i_valid && is_pfx && pfx_clean) |=> (!o_valid && state == ST_HELD));

   // R5: the word after a vector prefix is dropped
   a_r5_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP && i_valid) |=> !(o_valid || o_illegal || o_unsup));

   // R7: a held prefix with a wrong suffix is illegal
   a_r7_bad_suffix: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HELD && i_valid && !is_add) |=> (o_illegal && state == ST_IDLE));

   // R8: reserved bits make the prefix illegal
   a_r8_bad_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && i_valid && is_pfx && !pfx_clean) |=> (o_illegal && state == ST_IDLE));

endmodule

// File: rtl/addimm_alu.sv
module addimm_alu
   import addimm_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic                use_long,
   input  logic [REG_W-1:0]    ra,
   input  logic [IMM_LO_W-1:0] imm_lo,
   input  logic [IMM_HI_W-1:0] hold_hi,
   input  logic                hold_rel,
   input  logic [XLEN-1:0]     hold_addr,
   input  logic [XLEN-1:0]     rd_data,
   output logic [XLEN-1:0]     sum
);

   localparam int unsigned EXT_S = XLEN - IMM_LO_W;
   localparam int unsigned EXT_L = XLEN - IMM_W;

   generate
      if (XLEN <= IMM_W)
         $error("XLEN must exceed the long immediate width");
   endgenerate

   logic [XLEN-1:0]  imm_short;
   logic [XLEN-1:0]  imm_long;
   logic [IMM_W-1:0] joined;
   logic [XLEN-1:0]  reg_base;
   logic [XLEN-1:0]  base;

   assign joined    = {hold_hi, imm_lo};
   assign imm_short = {{EXT_S{imm_lo[IMM_LO_W-1]}}, imm_lo};
   assign imm_long  = {{EXT_L{joined[IMM_W-1]}}, joined};
   assign reg_base  = (ra == '0) ? '0 : rd_data;

   always_comb begin
      if (use_long) begin
         base = hold_rel ? hold_addr : reg_base;
         sum  = base + imm_long;
      end else begin
         base = reg_base;
         sum  = base + imm_short;
      end
   end

endmodule

// File: rtl/addimm_exec.sv
module addimm_exec
   import addimm_pkg::*;
#(
   parameter int unsigned XLEN     = 64,
   parameter int unsigned ADD_OPC  = 14,
   parameter int unsigned PFX_OPC  = 1,
   parameter int unsigned VEC_OPC  = 9,
   parameter int unsigned PFX_KIND = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic [XLEN-1:0]   in_addr,
   output logic [REG_W-1:0]  rd_idx,
   input  logic [XLEN-1:0]   rd_data,
   output logic              out_valid,
   output logic [REG_W-1:0]  out_rt,
   output logic [XLEN-1:0]   out_result,
   output logic              out_illegal,
   output logic              out_unsup
);

   word_fields_t        fld;
   logic                is_add, is_pfx, pfx_clean, is_vec;
   seq_state_e          st;
   logic                load;
   logic [IMM_HI_W-1:0] hold_hi;
   logic                hold_rel;
   logic [XLEN-1:0]     hold_addr;
   logic [XLEN-1:0]     sum;

   addimm_field_split #(
      .ADD_OPC (ADD_OPC),
      .PFX_OPC (PFX_OPC),
      .VEC_OPC (VEC_OPC),
      .PFX_KIND(PFX_KIND)
   ) u_split (
      .word     (in_word),
      .f        (fld),
      .is_add   (is_add),
      .is_pfx   (is_pfx),
      .pfx_clean(pfx_clean),
      .is_vec   (is_vec)
   );

   addimm_seq #(.XLEN(XLEN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .i_valid  (in_valid),
      .i_addr   (in_addr),
      .f        (fld),
      .is_add   (is_add),
      .is_pfx   (is_pfx),
      .pfx_clean(pfx_clean),
      .is_vec   (is_vec),
      .state    (st),
      .load     (load),
      .hold_hi  (hold_hi),
      .hold_rel (hold_rel),
      .hold_addr(hold_addr),
      .o_valid  (out_valid),
      .o_illegal(out_illegal),
      .o_unsup  (out_unsup)
   );

   addimm_alu #(.XLEN(XLEN)) u_alu (
      .use_long (st == ST_HELD),
      .ra       (fld.ra),
      .imm_lo   (fld.imm_lo),
      .hold_hi  (hold_hi),
      .hold_rel (hold_rel),
      .hold_addr(hold_addr),
      .rd_data  (rd_data),
      .sum      (sum)
   );

   assign rd_idx = fld.ra;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_rt     <= '0;
         out_result <= '0;
      end else if (load) begin
         out_rt     <= fld.rt;
         out_result <= sum;
      end
   end

   // R2: zero base field adds the short immediate to literal zero
   a_r2_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && in_valid && is_add && fld.ra == '0)
      |=> (out_valid && out_result == $past({{(XLEN-IMM_LO_W){in_word[15]}}, in_word[15:0]})));

   // R1: destination index follows the accepted word
   a_r1_rt_index: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && load) |=> (out_valid && out_rt == $past(in_word[25:21])));

endmodule

// File: tb/sim_addimm_exec.sv
`timescale 1ns/1ps
module sim_addimm_exec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic [63:0] in_addr = '0;
   logic [4:0]  rd_idx;
   logic [63:0] rd_data;
   logic        out_valid, out_illegal, out_unsup;
   logic [4:0]  out_rt;
   logic [63:0] out_result;

   logic [63:0] rf [32];
   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   assign rd_data = rf[rd_idx];

   addimm_exec u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .in_addr(in_addr), .rd_idx(rd_idx), .rd_data(rd_data),
      .out_valid(out_valid), .out_rt(out_rt), .out_result(out_result),
      .out_illegal(out_illegal), .out_unsup(out_unsup)
   );

   function automatic logic [63:0] sx16(input logic [15:0] v);
      return {{48{v[15]}}, v};
   endfunction

   function automatic logic [63:0] sx34(input logic [33:0] v);
      return {{30{v[33]}}, v};
   endfunction

   function automatic logic [31:0] w_add(input logic [4:0] rt, input logic [4:0] ra,
                                         input logic [15:0] si);
      return {6'd14, rt, ra, si};
   endfunction

   function automatic logic [31:0] w_pfx(input logic rel, input logic [17:0] hi,
                                         input logic [4:0] rsv);
      // rsv: {bit8, bits9-10, bits12-13}
      return {6'd1, 2'd2, rsv[4], rsv[3:2], rel, rsv[1:0], hi};
   endfunction

   function automatic logic [63:0] base_of(input logic [4:0] ra);
      return (ra == 5'd0) ? 64'd0 : rf[ra];
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic step(input logic v, input logic [31:0] w, input logic [63:0] a);
      in_valid = v;
      in_word  = w;
      in_addr  = a;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic flags(input string tag, input logic [2:0] exp);
      chk(tag, {61'd0, out_valid, out_illegal, out_unsup}, {61'd0, exp});
   endtask

   initial begin
      #(4 * 150000);
      bad++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
      rf[0] = 64'hDEAD_BEEF_0000_1111;

      repeat (3) @(negedge clk);
      flags("R9 in reset", 3'b000);
      rst_n = 1'b1;
      @(negedge clk);
      flags("R9 after reset", 3'b000);

      // R1 random short form
      for (int i = 0; i < 200; i++) begin
         logic [4:0] rt, ra; logic [15:0] si;
         rt = 5'($urandom); ra = 5'($urandom); si = 16'($urandom);
         if (i % 16 == 0) si = 16'h8000;
         if (i % 16 == 1) si = 16'hFFFF;
         step(1'b1, w_add(rt, ra, si), 64'($urandom));
         flags("R1 flags", 3'b100);
         chk("R1 rt", {59'd0, out_rt}, {59'd0, rt});
         chk("R1 result", out_result, base_of(ra) + sx16(si));
      end

      // R2 literal zero base
      step(1'b1, w_add(5'd7, 5'd0, 16'hFFF0), 64'h0);
      chk("R2 zero base", out_result, 64'hFFFF_FFFF_FFFF_FFF0);

      // R10 idle cycle
      step(1'b0, w_add(5'd3, 5'd3, 16'd1), 64'h0);
      flags("R10 idle quiet", 3'b000);

      // R3 / R4 random long form
      for (int i = 0; i < 120; i++) begin
         logic rel; logic [17:0] hi; logic [4:0] rt, ra; logic [15:0] lo;
         logic [63:0] pa, sa, exp;
         rel = 1'($urandom); hi = 18'($urandom); rt = 5'($urandom);
         ra = 5'($urandom); lo = 16'($urandom);
         pa = {$urandom, $urandom}; sa = {$urandom, $urandom};
         if (i == 0) begin hi = 18'h20000; lo = 16'h0000; end
         if (i == 1) begin hi = 18'h3FFFF; lo = 16'hFFFF; end
         if (i == 2) begin hi = 18'h1FFFF; lo = 16'hFFFF; rel = 1'b0; ra = 5'd0; end
         step(1'b1, w_pfx(rel, hi, 5'd0), pa);
         flags("R3 prefix silent", 3'b000);
         step(1'b1, w_add(rt, ra, lo), sa);
         exp = (rel ? pa : base_of(ra)) + sx34({hi, lo});
         flags(rel ? "R4 flags" : "R3 flags", 3'b100);
         chk(rel ? "R4 rt" : "R3 rt", {59'd0, out_rt}, {59'd0, rt});
         chk(rel ? "R4 pc-relative result" : "R3 long result", out_result, exp);
      end

      // R5 vector prefix, suffix dropped
      step(1'b1, {6'd9, 26'h0ABCDEF}, 64'h100);
      flags("R5 vector unsup", 3'b001);
      step(1'b1, w_add(5'd4, 5'd2, 16'd5), 64'h104);
      flags("R5 suffix dropped", 3'b000);
      step(1'b1, w_add(5'd4, 5'd2, 16'd5), 64'h108);
      chk("R5 resumes", out_result, rf[2] + 64'd5);

      // R6 other opcodes
      step(1'b1, {6'd31, 26'h1234567}, 64'h0);
      flags("R6 opcode 31", 3'b001);
      step(1'b1, {6'd1, 2'd1, 24'h0}, 64'h0);
      flags("R6 prefix kind 1", 3'b001);
      step(1'b1, {6'd0, 26'h0}, 64'h0);
      flags("R6 opcode 0", 3'b001);

      // R7 bad suffix
      step(1'b1, w_pfx(1'b1, 18'h1, 5'd0), 64'h2000);
      step(1'b1, {6'd15, 26'h0}, 64'h2004);
      flags("R7 bad suffix illegal", 3'b010);
      step(1'b1, w_add(5'd9, 5'd0, 16'd3), 64'h2008);
      chk("R7 next word fresh", out_result, 64'd3);

      // R8 reserved bits
      for (int k = 0; k < 5; k++) begin
         step(1'b1, w_pfx(1'b0, 18'h3, 5'(1 << k)), 64'h3000);
         flags("R8 reserved illegal", 3'b010);
         step(1'b1, w_add(5'd1, 5'd0, 16'd9), 64'h3004);
         chk("R8 no prefix held", out_result, 64'd9);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule